// File: doc/BRIEF.md
# Composite Sync Timing Separator

This block turns a one-bit composite sync stream into the timing strobes a video capture path needs. The input is already sliced and sampled on the system clock, with a low level meaning sync tip. From it the block produces six signals: a delayed copy of the sync, a horizontal pulse of fixed delay and width, a back-porch gate, a vertical pulse, a field parity flag and a loss-of-signal flag. Every delay, width and window is a count of clock cycles, set by a parameter that is scaled from the nominal line period.

A low run becomes a sync candidate only after it has lasted a minimum number of cycles. A candidate counts as a line edge only when at least three quarters of a line has passed since the previous line edge, so half-line equalizing pulses and serrations do not produce extra horizontal pulses. A low run that lasts longer than a broad-pulse threshold marks the vertical interval. Vertical sync is raised on the second broad pulse of the interval. If the vertical interval has no serrations, it is raised instead once a single low run has lasted a full default delay. The position of the first broad pulse relative to the line grid decides field parity.

Top module: `sync_timing_sep`

## Requirements
- R1: While reset is held, and after it is released with the input high, hsync_out, bp_gate, vsync_out and field_odd are 0, los_out is 1 and csync_out is 1.
- R2: csync_out equals csync_in delayed by CS_DLY+1 clock cycles, including short noise pulses.
- R3: A low run shorter than QUAL_CYC cycles produces no hsync_out, no bp_gate and no vsync_out. A low run of exactly QUAL_CYC cycles is a valid sync candidate.
- R4: When a falling edge of csync_in is accepted as a line edge, hsync_out rises HD_CYC+2 cycles after it and stays high for exactly HW_CYC cycles, whatever the width of the input pulse.
- R5: A candidate whose fall comes G cycles after the previous accepted fall is accepted only if G+QUAL_CYC-1 ≥ 3·LINE_CYC/4. While los_out is high, every candidate is accepted.
- R6: Take an accepted pulse that is shorter than BROAD_CYC cycles. bp_gate rises BD_CYC+2 cycles after its rising edge and stays high for exactly BW_CYC cycles. Rejected candidates produce no bp_gate.
- R7: A low run of at least BROAD_CYC cycles is a broad pulse. On the second broad pulse of an interval, vsync_out rises BROAD_CYC+1 cycles after that pulse falls and stays high for VW_CYC cycles.
- R8: If a single low run reaches VDD_CYC cycles, vsync_out rises VDD_CYC+1 cycles after its fall, even without a second broad pulse, and stays high for VW_CYC cycles.
- R9: Only one vsync_out pulse is produced per vertical interval. The interval ends, and vertical detection re-arms, only when a candidate shorter than BROAD_CYC cycles completes.
- R10: field_odd updates BROAD_CYC+1 cycles after the fall of the first broad pulse of an interval. It becomes 1 when that fall lies within LINE_CYC/4 cycles after the last accepted line edge, and 0 otherwise. Later broad pulses in the same interval leave it unchanged.
- R11: los_out rises LOS_LINES·LINE_CYC+1 cycles after the last accepted fall when no further fall is accepted. It clears QUAL_CYC+1 cycles after the next accepted fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_in | input | 1 | Sliced composite sync, low during sync |
| csync_out | output | 1 | Delayed copy of the input sync |
| hsync_out | output | 1 | Regenerated horizontal pulse, active high |
| bp_gate | output | 1 | Back-porch / burst gate, active high |
| vsync_out | output | 1 | Vertical sync pulse, active high |
| field_odd | output | 1 | Field parity, 1 for the line-aligned field |
| los_out | output | 1 | High while no valid sync is arriving |

## Verification
The bench targets the edges of the qualification rule. It applies runs one cycle below and exactly at the minimum width, and line spacings one cycle either side of the three-quarter-line gate; a design with an off-by-one there would emit a stray horizontal pulse or drop a real one. It applies both a line-aligned and a mid-line-aligned serrated vertical interval, followed by an interval with no serrations. A design that re-armed vertical detection on every broad pulse would show a second vertical pulse late in the interval. A design that re-evaluated parity on later broad pulses would flip field_odd partway through. Finally, the bench lets the line go silent long enough to raise loss of signal, then checks that the first returning edge both clears the flag and still produces a correctly timed horizontal pulse.

// File: rtl/sync_timing_sep.sv
module sync_timing_sep #(
  parameter int LINE_CYC  = 3178,
  parameter int QUAL_CYC  = 20,
  parameter int HD_CYC    = 22,
  parameter int HW_CYC    = 235,
  parameter int BD_CYC    = 21,
  parameter int BW_CYC    = 150,
  parameter int CS_DLY    = 3,
  parameter int BROAD_CYC = 1000,
  parameter int VDD_CYC   = 3178,
  parameter int VW_CYC    = 9750,
  parameter int LOS_LINES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_in,
  output logic csync_out,
  output logic hsync_out,
  output logic bp_gate,
  output logic vsync_out,
  output logic field_odd,
  output logic los_out
);

  localparam int LOS_CYC = LOS_LINES * LINE_CYC;
  localparam int SW = $clog2(LOS_CYC + 1);
  localparam int LW = $clog2(VDD_CYC + 1);
  localparam int VW = $clog2(VW_CYC + 1);
  localparam int PW = $clog2(BD_CYC + BW_CYC + 1);

  localparam logic [SW-1:0] S_LOS   = SW'(LOS_CYC);
  localparam logic [SW-1:0] S_QUAL  = SW'(QUAL_CYC);
  localparam logic [SW-1:0] S_GATE  = SW'((3 * LINE_CYC) / 4);
  localparam logic [SW-1:0] S_HD    = SW'(HD_CYC);
  localparam logic [SW-1:0] S_HD1   = SW'(HD_CYC + 1);
  localparam logic [SW-1:0] S_HEND  = SW'(HD_CYC + HW_CYC);
  localparam logic [SW-1:0] S_FWIN  = SW'(BROAD_CYC + LINE_CYC / 4);
  localparam logic [LW-1:0] L_QUAL1 = LW'(QUAL_CYC - 1);
  localparam logic [LW-1:0] L_QUAL  = LW'(QUAL_CYC);
  localparam logic [LW-1:0] L_BRD1  = LW'(BROAD_CYC - 1);
  localparam logic [LW-1:0] L_BRD   = LW'(BROAD_CYC);
  localparam logic [LW-1:0] L_VDD1  = LW'(VDD_CYC - 1);
  localparam logic [LW-1:0] L_VDD   = LW'(VDD_CYC);
  localparam logic [PW-1:0] P_BD    = PW'(BD_CYC);
  localparam logic [PW-1:0] P_END   = PW'(BD_CYC + BW_CYC);
  localparam logic [VW-1:0] V_LEN   = VW'(VW_CYC);

  logic              s0, s0_d;
  logic [CS_DLY-1:0] dly;
  logic [LW-1:0]     low_cnt;
  logic [SW-1:0]     since_cnt;
  logic [PW-1:0]     post_cnt;
  logic [VW-1:0]     vcnt;
  logic              line_low, broad_seen, v_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0   <= 1'b1;
      s0_d <= 1'b1;
      dly  <= '1;
    end else begin
      s0     <= csync_in;
      s0_d   <= s0;
      dly[0] <= s0;
      for (int k = 1; k < CS_DLY; k++) dly[k] <= dly[k-1];
    end
  end

  assign csync_out = dly[CS_DLY-1];

  wire rise      = s0 && !s0_d;
  wire qual_hit  = !s0 && (low_cnt == L_QUAL1);
  wire broad_hit = !s0 && (low_cnt == L_BRD1);
  wire long_hit  = !s0 && (low_cnt == L_VDD1);
  wire short_end = rise && (low_cnt >= L_QUAL) && (low_cnt < L_BRD);
  wire accept    = qual_hit && (since_cnt >= S_GATE);
  wire v_start   = !v_done && ((broad_hit && broad_seen) || long_hit);
  wire par_upd   = broad_hit && !broad_seen && !v_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= '0;
    else if (s0)             low_cnt <= '0;
    else if (low_cnt != L_VDD) low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_cnt <= S_LOS;
    else if (accept)             since_cnt <= S_QUAL;
    else if (since_cnt != S_LOS) since_cnt <= since_cnt + 1'b1;
  end

  assign los_out = (since_cnt == S_LOS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hsync_out <= 1'b0;
    else        hsync_out <= (since_cnt >= S_HD) && (since_cnt < S_HEND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      line_low <= 1'b0;
    else if (accept) line_low <= 1'b1;
    else if (rise)   line_low <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_cnt <= '0;
      bp_gate  <= 1'b0;
    end else begin
      if (rise && line_low && (low_cnt < L_BRD)) post_cnt <= PW'(1);
      else if (post_cnt != '0) post_cnt <= (post_cnt == P_END) ? '0 : post_cnt + 1'b1;
      bp_gate <= (post_cnt >= P_BD) && (post_cnt < P_END);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      broad_seen <= 1'b0;
      v_done     <= 1'b0;
      vcnt       <= '0;
      field_odd  <= 1'b0;
    end else begin
      if (short_end)      broad_seen <= 1'b0;
      else if (broad_hit) broad_seen <= 1'b1;
      if (short_end)      v_done <= 1'b0;
      else if (v_start)   v_done <= 1'b1;
      if (v_start)        vcnt <= V_LEN;
      else if (vcnt != '0) vcnt <= vcnt - 1'b1;
      if (par_upd)        field_odd <= (since_cnt < S_FWIN);
    end
  end

  assign vsync_out = (vcnt != '0);

  p_los_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !los_out);

  p_hsync_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_out) |-> (since_cnt == S_HD1));

  p_hsync_no_los_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_out |-> !los_out);

  p_vsync_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_out) |-> v_done);

  p_field_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(v_done) |-> $stable(field_odd));

endmodule

// File: tb/sync_timing_sep_bench.sv
module sync_timing_sep_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync = 1'b1;
  logic cso, hs, bp, vs, fo, los;

  always #10 clk = ~clk;

  sync_timing_sep #(
    .LINE_CYC(200), .QUAL_CYC(8), .HD_CYC(12), .HW_CYC(30), .BD_CYC(10),
    .BW_CYC(40), .CS_DLY(4), .BROAD_CYC(60), .VDD_CYC(200), .VW_CYC(300),
    .LOS_LINES(4)
  ) u_sync_timing_sep (
    .clk(clk), .rst_n(rst_n), .csync_in(csync), .csync_out(cso),
    .hsync_out(hs), .bp_gate(bp), .vsync_out(vs), .field_odd(fo), .los_out(los)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic h_prev = 1'b0, bp_prev = 1'b0, cs_prev = 1'b1;
  logic vs_log [0:2047];
  logic fo_log [0:2047];
  logic los_log [0:2047];
  int h_off, bp_off, cs_off, h_len, bp_len;
  bit vs_any;

  // {low cycles, high cycles, expected hsync offset, expected bp offset}; -1 = none
  localparam int NV = 17;
  localparam int VEC [NV][4] = '{
    '{30, 170, 14, 12}, '{30, 170, 14, 12}, '{30, 70, 14, 12}, '{15, 85, -1, -1},
    '{30, 70, 14, 12},  '{5, 95, -1, -1},   '{4, 96, -1, -1},  '{30, 170, 14, 12},
    '{30, 170, 14, 12}, '{8, 192, 14, 12},  '{7, 193, -1, -1}, '{30, 170, 14, 12},
    '{30, 113, 14, 12}, '{30, 170, 14, 12}, '{30, 112, 14, 12}, '{30, 170, -1, -1},
    '{30, 170, 14, 12}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic seg(input int lo, input int hi);
    h_off = -1; bp_off = -1; cs_off = -1; h_len = 0; bp_len = 0; vs_any = 1'b0;
    for (int i = 0; i < lo + hi; i++) begin
      @(negedge clk);
      if (hs && !h_prev && h_off < 0) h_off = i;
      if (bp && !bp_prev && bp_off < 0) bp_off = i - lo;
      if (!cso && cs_prev && cs_off < 0) cs_off = i;
      if (hs) h_len++;
      if (bp) bp_len++;
      if (vs) vs_any = 1'b1;
      if (i < 2048) begin
        vs_log[i] = vs; fo_log[i] = fo; los_log[i] = los;
      end
      h_prev = hs; bp_prev = bp; cs_prev = cso;
      csync = (i >= lo);
    end
  endtask

  task automatic broads(input bit odd);
    for (int b = 0; b < 6; b++) begin
      seg(80, 20);
      if (b == 0) check(fo_log[60] == !odd && fo_log[61] == odd, "R10 parity update",
                        int'(fo_log[61]), int'(odd));
      if (b == 1) check(!vs_log[60] && vs_log[61], "R7 vsync rise on 2nd broad",
                        int'(vs_log[61]), 1);
      if (b == 4) check(vs_log[60] && !vs_log[61], "R7 vsync width", int'(vs_log[61]), 0);
      if (b == 5) check(!vs_any, "R9 single vsync per interval", int'(vs_any), 0);
    end
    check(fo == odd, "R10 parity held through interval", int'(fo), int'(odd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!hs && !bp && !vs && !fo && los && cso, "R1 in reset",
          {hs, bp, vs, fo, los, cso}, 6'b000011);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!hs && !bp && !vs && !fo && los && cso, "R1 after reset",
          {hs, bp, vs, fo, los, cso}, 6'b000011);

    // table: R2 R3 R4 R5 R6
    for (int r = 0; r < NV; r++) begin
      seg(VEC[r][0], VEC[r][1]);
      check(h_off == VEC[r][2], $sformatf("R4/R5/R3 hsync offset row %0d", r), h_off, VEC[r][2]);
      check(h_len == (VEC[r][2] < 0 ? 0 : 30), $sformatf("R4 hsync width row %0d", r),
            h_len, VEC[r][2] < 0 ? 0 : 30);
      check(bp_off == VEC[r][3], $sformatf("R6 bp offset row %0d", r), bp_off, VEC[r][3]);
      check(bp_len == (VEC[r][3] < 0 ? 0 : 40), $sformatf("R6 bp width row %0d", r),
            bp_len, VEC[r][3] < 0 ? 0 : 40);
      check(cs_off == 5, $sformatf("R2 csync delay row %0d", r), cs_off, 5);
      check(!vs_any, $sformatf("R3 no vsync row %0d", r), int'(vs_any), 0);
      if (r == 0) check(los_log[8] && !los_log[9], "R11 los clears on first edge",
                        int'(los_log[9]), 0);
    end

    // line-aligned serrated interval
    seg(30, 170); seg(30, 170);
    broads(1'b1);
    seg(30, 170); seg(30, 170);

    // mid-line serrated interval
    seg(30, 70);
    broads(1'b0);
    seg(30, 170); seg(30, 170); seg(30, 170);

    // interval without serrations
    seg(30, 170);
    seg(500, 170);
    check(!fo_log[60] && fo_log[61], "R10 parity on long pulse", int'(fo_log[61]), 1);
    check(!vs_log[200] && vs_log[201], "R8 default vsync delay", int'(vs_log[201]), 1);
    check(vs_log[500] && !vs_log[501], "R8 vsync width", int'(vs_log[501]), 0);
    seg(30, 170); seg(30, 170);

    // loss of signal and recovery
    seg(30, 1000);
    check(!los_log[800] && los_log[801], "R11 los timeout", int'(los_log[801]), 1);
    seg(30, 170);
    check(los_log[8] && !los_log[9], "R11 los clear", int'(los_log[9]), 0);
    check(h_off == 14, "R5 edge accepted during los", h_off, 14);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule